// File: doc/BRIEF.md
# Burst Ready and Latency Controller

This block decides, cycle by cycle, whether a synchronous burst memory port has a valid word for the host. It drives a ready output that is low while the host must wait. It also drives an advance enable that tells the external address sequencer to step to the next word. A burst starts when an address-latch strobe arrives while the chip is enabled. The controller then counts down an initial latency. That latency is set by a configuration input and is stretched when the clock is marked as slow, or when the reduced-wait variant starts near the end of a 64-word block. After the latency, the controller streams one word per clock.

In linear bursts, the controller inserts a two-cycle wait after the word at the last offset of each 64-word block. The first such wait is skipped when the burst started at one of the last two offsets of a block. Wrap bursts never pause after the initial access. Raising output enable while write enable is inactive suspends the burst: every counter is frozen and ready keeps its value. A new strobe always restarts the burst. Deselecting the chip returns the controller to idle.

The states are IDLE (no burst, ready high), INIT (initial countdown, ready low), DATA (streaming, ready high), GAP (block-boundary wait, ready low) and SUSP (suspended, with the interrupted state stored for the resume). The transitions are: strobe to INIT, or straight to DATA when the latency is zero. INIT expiry goes to DATA. A boundary word goes from DATA to GAP, and GAP expiry returns to DATA. Hold goes from INIT, DATA or GAP to SUSP, and release goes from SUSP back to the stored state. Chip deselect goes from any state to IDLE.

Top module: `burst_rdy_ctrl`

## Requirements
- R1: After reset, `rdy` is 1 and `adv_en` is 0.
- R2: After a strobe (`addr_vld`=1 with `ce_n`=0) is sampled, `rdy` is 0 for exactly the initial count of clock cycles. The initial count is `lat_cfg` plus the extras from R6 and R8. A count of 0 gives `rdy`=1 in the very next cycle.
- R3: In the data phase, `rdy`=1 and `adv_en`=1 in every cycle, so the sequencer moves one address per clock.
- R4: With `wrap_mode`=0, a data cycle with `cur_addr[5:0]`=6'h3F is followed by 2 cycles of `rdy`=0 and `adv_en`=0, then streaming resumes.
- R5: With `reduced_hs`=0 and `start_addr[5:0]` equal to 6'h3E or 6'h3F, the first boundary of the burst has no wait. Later boundaries follow R4.
- R6: With `reduced_hs`=1 and `start_addr[5:0]` equal to 6'h3E or 6'h3F, the initial count grows by 2 and the first boundary has no wait.
- R7: With `wrap_mode`=1, `rdy` never falls after the initial access unless a new strobe arrives.
- R8: `slow_clk`=1 at the strobe adds one cycle to the initial count.
- R9: While `ce_n`=0, `oe_n`=1 and `we_n`=1, the burst is held. `adv_en` is 0, `rdy` keeps its value, no countdown moves, and after release the burst continues where it stopped.
- R10: With `oe_n`=1 but `we_n`=0, no hold occurs and streaming continues.
- R11: A strobe in any state, including a boundary wait, restarts the initial countdown from the new address.
- R12: With `ce_n`=1, the block goes idle (`rdy`=1, `adv_en`=0) and a strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_vld | input | 1 | Address-latch strobe, active high |
| start_addr | input | AW | Burst start address, sampled with the strobe |
| cur_addr | input | AW | Address of the word being output, from the sequencer |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wrap_mode | input | 1 | 1 = wrap burst, 0 = linear burst |
| reduced_hs | input | 1 | 1 = reduced-wait handshake variant |
| slow_clk | input | 1 | Clock below the speed threshold |
| lat_cfg | input | LATW | Configured initial latency in cycles |
| rdy | output | 1 | Word valid; low while waiting |
| adv_en | output | 1 | Step the address sequencer at this edge |

## Verification
The assertions assume that `cur_addr` comes from a sequencer that loads `start_addr` on a strobe and increments only when `adv_en` is high. They also assume that `wrap_mode`, `reduced_hs`, `slow_clk` and `lat_cfg` are steady during a burst. The bench builds exactly such a sequencer around the design. It changes the mode inputs only together with a strobe. It keeps `oe_n` low whenever it issues a strobe, so a hold never overlaps a restart.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_DATA,
        ST_GAP,
        ST_SUSP
    } brc_state_e;
endpackage

// File: rtl/brc_init_calc.sv
module brc_init_calc #(
    parameter int AW         = 23,
    parameter int BLK_W      = 6,
    parameter int LATW       = 4,
    parameter int SLOW_EXTRA = 1,
    parameter int GAP_CYC    = 2,
    parameter int CNTW       = 5
) (
    input  logic [AW-1:0]   start_addr,
    input  logic [LATW-1:0] lat_cfg,
    input  logic            slow_clk,
    input  logic            reduced_hs,
    output logic [CNTW-1:0] init_cnt,
    output logic            late_start
);
    // start offset is one of the last two words of its block
    assign late_start = &start_addr[BLK_W-1:1];

    always_comb begin
        init_cnt = CNTW'(lat_cfg);
        if (slow_clk)
            init_cnt = init_cnt + CNTW'(SLOW_EXTRA);
        if (reduced_hs && late_start)
            init_cnt = init_cnt + CNTW'(GAP_CYC);
    end
endmodule

// File: rtl/brc_boundary_det.sv
module brc_boundary_det #(
    parameter int AW    = 23,
    parameter int BLK_W = 6
) (
    input  logic [AW-1:0] cur_addr,
    input  logic          wrap_mode,
    input  logic          skip_pend,
    output logic          at_edge,
    output logic          gap_req
);
    assign at_edge = !wrap_mode && (&cur_addr[BLK_W-1:0]);
    assign gap_req = at_edge && !skip_pend;
endmodule

// File: rtl/burst_rdy_ctrl.sv
module burst_rdy_ctrl #(
    parameter int AW         = 23,
    parameter int BLK_W      = 6,
    parameter int LATW       = 4,
    parameter int SLOW_EXTRA = 1,
    parameter int GAP_CYC    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_vld,
    input  logic [AW-1:0]   start_addr,
    input  logic [AW-1:0]   cur_addr,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic            wrap_mode,
    input  logic            reduced_hs,
    input  logic            slow_clk,
    input  logic [LATW-1:0] lat_cfg,
    output logic            rdy,
    output logic            adv_en
);
    import brc_pkg::*;

    localparam int CNTW = $clog2((1 << LATW) + SLOW_EXTRA + GAP_CYC);

    brc_state_e      state_q, state_d;
    brc_state_e      ret_q, ret_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic            skip_q, skip_d;

    logic [CNTW-1:0] init_cnt;
    logic            late_start;
    logic            at_edge;
    logic            gap_req;
    logic            hold;

    brc_init_calc #(
        .AW(AW), .BLK_W(BLK_W), .LATW(LATW),
        .SLOW_EXTRA(SLOW_EXTRA), .GAP_CYC(GAP_CYC), .CNTW(CNTW)
    ) init_i (
        .start_addr (start_addr),
        .lat_cfg    (lat_cfg),
        .slow_clk   (slow_clk),
        .reduced_hs (reduced_hs),
        .init_cnt   (init_cnt),
        .late_start (late_start)
    );

    brc_boundary_det #(
        .AW(AW), .BLK_W(BLK_W)
    ) edge_i (
        .cur_addr  (cur_addr),
        .wrap_mode (wrap_mode),
        .skip_pend (skip_q),
        .at_edge   (at_edge),
        .gap_req   (gap_req)
    );

    assign hold = !ce_n && oe_n && we_n;

    // next-state logic
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        cnt_d   = cnt_q;
        skip_d  = skip_q;
        if (ce_n) begin
            state_d = ST_IDLE;
        end else if (addr_vld) begin
            skip_d = late_start;
            if (init_cnt == '0) begin
                state_d = ST_DATA;
            end else begin
                state_d = ST_INIT;
                cnt_d   = init_cnt;
            end
        end else if (hold) begin
            if (state_q == ST_INIT || state_q == ST_DATA || state_q == ST_GAP) begin
                state_d = ST_SUSP;
                ret_d   = state_q;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_INIT, ST_GAP: begin
                    if (cnt_q <= CNTW'(1))
                        state_d = ST_DATA;
                    else
                        cnt_d = cnt_q - CNTW'(1);
                end
                ST_DATA: begin
                    if (at_edge) begin
                        skip_d = 1'b0;
                        if (gap_req) begin
                            state_d = ST_GAP;
                            cnt_d   = CNTW'(GAP_CYC);
                        end
                    end
                end
                ST_SUSP: state_d = ret_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
            cnt_q   <= '0;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            cnt_q   <= cnt_d;
            skip_q  <= skip_d;
        end
    end

    // outputs
    always_comb begin
        rdy    = 1'b1;
        adv_en = 1'b0;
        unique case (state_q)
            ST_IDLE:         rdy = 1'b1;
            ST_INIT, ST_GAP: rdy = 1'b0;
            ST_DATA: begin
                rdy    = 1'b1;
                adv_en = !hold;
            end
            ST_SUSP:         rdy = (ret_q == ST_DATA);
            default:         rdy = 1'b1;
        endcase
    end
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int LATW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            addr_vld,
    input logic            ce_n,
    input logic            oe_n,
    input logic            we_n,
    input logic            wrap_mode,
    input logic [LATW-1:0] lat_cfg,
    input logic            rdy,
    input logic            adv_en
);
    p_strobe_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && !ce_n && lat_cfg != '0) |=> !rdy);

    p_adv_has_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |-> rdy);

    p_wrap_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_mode && rdy && !addr_vld) |=> rdy);

    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && we_n && !addr_vld) |=> (!adv_en && $stable(rdy)));

    p_idle_on_deselect_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (rdy && !adv_en));
endmodule

bind burst_rdy_ctrl brc_checker #(.LATW(LATW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_vld  (addr_vld),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .wrap_mode (wrap_mode),
    .lat_cfg   (lat_cfg),
    .rdy       (rdy),
    .adv_en    (adv_en)
);

// File: tb/burst_rdy_ctrl_tb_top.sv
`timescale 1ns/1ps
module burst_rdy_ctrl_tb_top;
    localparam int AW   = 23;
    localparam int LATW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            addr_vld = 1'b0;
    logic [AW-1:0]   start_addr = '0;
    logic [AW-1:0]   cur_addr = '0;
    logic            ce_n = 1'b0;
    logic            oe_n = 1'b0;
    logic            we_n = 1'b1;
    logic            wrap_mode = 1'b0;
    logic            reduced_hs = 1'b0;
    logic            slow_clk = 1'b0;
    logic [LATW-1:0] lat_cfg = '0;
    logic            rdy;
    logic            adv_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_rdy_ctrl #(.AW(AW), .LATW(LATW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .start_addr(start_addr),
        .cur_addr(cur_addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wrap_mode(wrap_mode), .reduced_hs(reduced_hs), .slow_clk(slow_clk),
        .lat_cfg(lat_cfg), .rdy(rdy), .adv_en(adv_en)
    );

    // address sequencer model
    always @(posedge clk) begin
        if (!ce_n && addr_vld)
            cur_addr <= start_addr;
        else if (adv_en)
            cur_addr <= cur_addr + 1'b1;
    end

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(input int addr, input int lat, input bit red,
                          input bit slow, input bit wrp);
        start_addr = AW'(addr);
        lat_cfg    = LATW'(lat);
        reduced_hs = red;
        slow_clk   = slow;
        wrap_mode  = wrp;
        addr_vld   = 1'b1;
        @(negedge clk);
        addr_vld   = 1'b0;
    endtask

    // count consecutive negedges where rdy equals val (current one first)
    task automatic run_len(input bit val, input int limit, output int n);
        n = 0;
        while (rdy == val && n < limit) begin
            if (val && !adv_en) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check(int'(rdy), 1, "R1 rdy");
        check(int'(adv_en), 0, "R1 adv_en");
    endtask

    task automatic t_basic;
        int n;
        strobe(16'h10, 5, 0, 0, 0);
        run_len(0, 200, n); check(n, 5, "R2 initial latency");
        run_len(1, 200, n); check(n, 48, "R3 stream 10..3F");
        run_len(0, 200, n); check(n, 2, "R4 boundary gap");
        check(int'(cur_addr), 'h40, "R4 next address");
    endtask

    task automatic t_lat_zero;
        int n;
        strobe(5, 0, 0, 0, 0);
        check(int'(rdy), 1, "R2 zero latency rdy");
        check(int'(adv_en), 1, "R3 zero latency adv");
        run_len(1, 200, n); check(n, 59, "R3 stream 05..3F");
    endtask

    task automatic t_std_boundary;
        int n;
        strobe('h3A, 3, 0, 0, 0);
        run_len(0, 200, n); check(n, 3, "R2 lat 3");
        run_len(1, 200, n); check(n, 6, "R4 words 3A..3F");
        run_len(0, 200, n); check(n, 2, "R4 gap length");
        run_len(1, 200, n); check(n, 64, "R4 words 40..7F");
    endtask

    task automatic t_std_late;
        int n;
        strobe('h3E, 3, 0, 0, 0);
        run_len(0, 200, n); check(n, 3, "R5 initial unchanged");
        run_len(1, 200, n); check(n, 66, "R5 first boundary skipped");
        run_len(0, 200, n); check(n, 2, "R5 later boundary gap");
    endtask

    task automatic t_red_late;
        int n;
        strobe('h3F, 3, 1, 0, 0);
        run_len(0, 200, n); check(n, 5, "R6 initial plus 2");
        run_len(1, 200, n); check(n, 65, "R6 first boundary skipped");
        strobe('h3A, 3, 1, 0, 0);
        run_len(0, 200, n); check(n, 3, "R6 early start no extra");
        run_len(1, 200, n); check(n, 6, "R6 early start words");
        run_len(0, 200, n); check(n, 2, "R6 early start gap");
    endtask

    task automatic t_wrap;
        int n;
        strobe('h3A, 2, 0, 0, 1);
        run_len(0, 200, n); check(n, 2, "R7 initial");
        run_len(1, 100, n); check(n, 100, "R7 no gap in wrap");
    endtask

    task automatic t_slow;
        int n;
        strobe('h00, 3, 0, 1, 0);
        run_len(0, 200, n); check(n, 4, "R8 slow clock extra");
        strobe('h3E, 2, 1, 1, 0);
        run_len(0, 200, n); check(n, 5, "R8 slow plus late start");
    endtask

    task automatic t_suspend;
        int n;
        bit ok;
        strobe('h00, 2, 0, 0, 0);
        run_len(0, 200, n); check(n, 2, "R2 before hold");
        repeat (3) @(negedge clk);
        oe_n = 1'b1;
        ok = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (rdy !== 1'b1 || adv_en !== 1'b0 || cur_addr != 3) ok = 1'b0;
        end
        check(int'(ok), 1, "R9 data held");
        check(int'(cur_addr), 3, "R9 address frozen");
        oe_n = 1'b0;
        @(negedge clk);
        run_len(1, 200, n); check(n, 61, "R9 resume 03..3F");
        // hold during initial access
        strobe('h00, 6, 0, 0, 0);
        @(negedge clk);
        oe_n = 1'b1;
        ok = 1'b1;
        repeat (5) begin
            @(negedge clk);
            if (rdy !== 1'b0 || adv_en !== 1'b0) ok = 1'b0;
        end
        check(int'(ok), 1, "R9 initial wait held");
        oe_n = 1'b0;
        @(negedge clk);
        run_len(0, 200, n); check(n, 5, "R9 countdown resumes");
    endtask

    task automatic t_write_no_hold;
        int n;
        strobe('h00, 1, 0, 0, 0);
        run_len(0, 200, n); check(n, 1, "R2 lat 1");
        oe_n = 1'b1; we_n = 1'b0;
        n = 0;
        repeat (3) begin
            if (adv_en) n++;
            @(negedge clk);
        end
        oe_n = 1'b0; we_n = 1'b1;
        check(n, 3, "R10 advances with write active");
        check(int'(cur_addr), 3, "R10 address moved");
    endtask

    task automatic t_restart;
        int n;
        strobe('h3A, 3, 0, 0, 0);
        run_len(0, 200, n);
        run_len(1, 200, n);
        check(int'(rdy), 0, "R11 in gap");
        strobe('h20, 4, 0, 0, 0);
        run_len(0, 200, n); check(n, 4, "R11 fresh latency");
        run_len(1, 200, n); check(n, 32, "R11 new burst 20..3F");
    endtask

    task automatic t_deselect;
        bit ok;
        ce_n = 1'b1;
        @(negedge clk);
        check(int'(rdy), 1, "R12 idle rdy");
        check(int'(adv_en), 0, "R12 idle adv");
        strobe('h10, 3, 0, 0, 0);
        ok = 1'b1;
        repeat (3) begin
            if (rdy !== 1'b1 || adv_en !== 1'b0) ok = 1'b0;
            @(negedge clk);
        end
        ce_n = 1'b0;
        @(negedge clk);
        check(int'(ok), 1, "R12 strobe ignored");
        check(int'(rdy && !adv_en), 1, "R12 stays idle");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lat_zero();
        t_std_boundary();
        t_std_late();
        t_red_late();
        t_wrap();
        t_slow();
        t_suspend();
        t_write_no_hold();
        t_restart();
        t_deselect();
        finish_run();
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule